// File: doc/BRIEF.md
# Write-Per-Bit Lane Mask Controller

This block sits beside the write path of a four-lane video memory and decides, once per row cycle, which data lanes may be written. It watches the active-low row strobe, column strobe and write-enable, which are sampled on the system clock. A falling row strobe is the moment of decision. At that point the write-enable and the special-function select set the cycle's masking mode, and the data pins may supply a new mask.

Three modes exist. With write-enable high at the row fall, the cycle is unmasked and every lane is enabled. With write-enable low and the function select low, the mask is reloaded from the data pins and applied. With write-enable low and the function select high, the stored mask is applied unchanged, so one mask can serve any number of row cycles. A separate load pulse can also refresh the stored mask at any time. The block also emits a one-cycle strobe that marks when write data is to be captured: the later of the column-strobe and write-enable falls inside the row cycle.

All pins are plain level or pulse signals. There is no streaming interface and no back-pressure.

Top module: `wpb_mask_unit`

## Requirements
- R1: After reset `lane_wen` is all ones and `data_take` is 0.
- R2: If `we_n` is 1 when `ras_n` is first sampled low, `lane_wen` is all ones for that row cycle and the stored mask is not changed.
- R3: If `we_n` is 0 and `dsf` is 0 when `ras_n` is first sampled low, the stored mask is loaded from `dq` at that edge, and `lane_wen` equals that `dq` value from that edge on.
- R4: If `we_n` is 0 and `dsf` is 1 when `ras_n` is first sampled low, `lane_wen` equals the previously stored mask from that edge on.
- R5: Bit i of `dq` and of `lane_wen` belongs to lane i. A 1 enables the write on that lane and a 0 blocks it.
- R6: `lane_wen` keeps its value at every edge where `ras_n` stays low. It returns to all ones at the first edge where `ras_n` is sampled high.
- R7: `data_take` is high, combinationally, in the first cycle after the row fall edge in which `cas_n` and `we_n` are both low. It fires again only after `cas_n` has gone high and fallen again within the same row cycle.
- R8: A `mask_load` pulse stores `dq` as the mask at that edge. The new mask appears at `lane_wen` in the next persistent cycle.
- R9: A `mask_load` during a row cycle does not change `lane_wen` before that row cycle ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, sampled |
| cas_n | input | 1 | Column strobe, active low, sampled |
| we_n | input | 1 | Write enable, active low, sampled |
| dsf | input | 1 | Special-function select: 0 reloads the mask, 1 keeps it |
| dq | input | LANES | Data pins carrying the mask value |
| mask_load | input | 1 | One-cycle request to store `dq` as the mask |
| lane_wen | output | LANES | Per-lane write enable for the row cycle |
| data_take | output | 1 | Write-data capture strobe |

## Verification
A corrupted stored mask stays hidden through unmasked and reloading cycles. It shows at `lane_wen` only at the first edge of the next persistent row cycle, so the random stimulus mixes long runs of persistent cycles with loads. Errors in the row-cycle tracking show within one cycle, as `lane_wen` changing while the row strobe is low or failing to return to all ones. Errors in the capture tracking show as a missing or repeated `data_take` pulse within the same column cycle.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  typedef enum logic [1:0] {
    WPB_NONE   = 2'd0,
    WPB_OFF    = 2'd1,
    WPB_RELOAD = 2'd2,
    WPB_KEEP   = 2'd3
  } wpb_mode_e;
endpackage

// File: rtl/wpb_strobe_sync.sv
module wpb_strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_strb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= strb_n[i];
    end
    assign fall[i] = prev_q[i] & ~strb_n[i];
  end
endmodule

// File: rtl/wpb_cycle_ctl.sv
module wpb_cycle_ctl
  import wpb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ras_fall,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  input  logic      dsf,
  output wpb_mode_e mode,
  output logic      data_take
);
  logic in_row_q;
  logic taken_q;

  always_comb begin
    if (!ras_fall)  mode = WPB_NONE;
    else if (we_n)  mode = WPB_OFF;
    else if (dsf)   mode = WPB_KEEP;
    else            mode = WPB_RELOAD;
  end

  assign data_take = in_row_q & ~taken_q & ~cas_n & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_row_q <= 1'b0;
      taken_q  <= 1'b0;
    end else begin
      if (ras_fall)   in_row_q <= 1'b1;
      else if (ras_n) in_row_q <= 1'b0;
      if (cas_n || ras_n) taken_q <= 1'b0;
      else if (data_take) taken_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wpb_mask_reg.sv
module wpb_mask_reg
  import wpb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wpb_mode_e        mode,
  input  logic             ras_n,
  input  logic             mask_load,
  input  logic [LANES-1:0] dq,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] wen_q
);
  localparam logic [LANES-1:0] ALL_ON = {LANES{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= ALL_ON;
      wen_q  <= ALL_ON;
    end else begin
      if (mode == WPB_RELOAD || mask_load) mask_q <= dq;
      if (ras_n) wen_q <= ALL_ON;
      else begin
        case (mode)
          WPB_OFF:    wen_q <= ALL_ON;
          WPB_RELOAD: wen_q <= dq;
          WPB_KEEP:   wen_q <= mask_q;
          default:    wen_q <= wen_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/wpb_mask_unit.sv
module wpb_mask_unit
  import wpb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             dsf,
  input  logic [LANES-1:0] dq,
  input  logic             mask_load,
  output logic [LANES-1:0] lane_wen,
  output logic             data_take
);
  localparam int NSTRB = 1;

  logic [NSTRB-1:0] falls;
  wpb_mode_e        mode;
  logic [LANES-1:0] mask_q;

  wpb_strobe_sync #(.N(NSTRB)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb_n (ras_n),
    .fall   (falls)
  );

  wpb_cycle_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_fall  (falls[0]),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dsf       (dsf),
    .mode      (mode),
    .data_take (data_take)
  );

  wpb_mask_reg #(.LANES(LANES)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ras_n     (ras_n),
    .mask_load (mask_load),
    .dq        (dq),
    .mask_q    (mask_q),
    .wen_q     (lane_wen)
  );
endmodule

// File: rtl/wpb_mask_checker.sv
module wpb_mask_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             we_n,
  input logic             dsf,
  input logic [LANES-1:0] dq,
  input logic [LANES-1:0] mask_q,
  input logic [LANES-1:0] lane_wen,
  input logic             data_take
);
  logic ras_prev;
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev <= 1'b1;
      seen     <= 1'b0;
    end else begin
      ras_prev <= ras_n;
      seen     <= 1'b1;
    end
  end
  wire rf = ras_prev & ~ras_n;

  a_r2_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (rf && we_n) |=> (lane_wen == {LANES{1'b1}}));
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rf && !we_n && !dsf) |=> (lane_wen == $past(dq)));
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rf && !we_n && dsf) |=> (lane_wen == $past(mask_q)));
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |=> (lane_wen == {LANES{1'b1}}));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ras_n && !ras_prev) |=> $stable(lane_wen));
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> !data_take);
endmodule

bind wpb_mask_unit wpb_mask_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .we_n      (we_n),
  .dsf       (dsf),
  .dq        (dq),
  .mask_q    (mask_q),
  .lane_wen  (lane_wen),
  .data_take (data_take)
);

// File: tb/sim_wpb_mask_unit.sv
`timescale 1ns/1ps
module sim_wpb_mask_unit;
  localparam int L = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0, mask_load = 1'b0;
  logic [L-1:0] dq = '0;
  logic [L-1:0] lane_wen;
  logic data_take;
  int checks = 0, fails = 0;

  // bench model state, from the requirements
  logic m_rq = 1'b1, m_inrow = 1'b0, m_taken = 1'b0;
  logic [L-1:0] m_mask = '1, m_wen = '1;
  string m_tag = "R1";

  always #5 clk = ~clk;

  wpb_mask_unit #(.LANES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dsf(dsf), .dq(dq), .mask_load(mask_load),
    .lane_wen(lane_wen), .data_take(data_take)
  );

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic exp_take(input logic c, input logic w);
    return m_inrow & ~m_taken & ~c & ~w;
  endfunction

  // one clock: check registered output, drive, check combinational, advance model
  task automatic step(input logic r, input logic c, input logic w,
                      input logic d, input logic [L-1:0] q, input logic m);
    logic fall;
    logic t;
    @(negedge clk);
    chk(m_tag, lane_wen, m_wen);
    ras_n = r; cas_n = c; we_n = w; dsf = d; dq = q; mask_load = m;
    #1;
    t = exp_take(c, w);
    chk("R7", {{(L-1){1'b0}}, data_take}, {{(L-1){1'b0}}, t});
    fall = m_rq & ~r;
    if (r) begin m_wen = '1; m_tag = "R6"; end
    else if (fall) begin
      if (w)      begin m_wen = '1;     m_tag = "R2"; end
      else if (d) begin m_wen = m_mask; m_tag = "R4"; end
      else        begin m_wen = q;      m_tag = "R3"; end
    end else m_tag = "R6";
    if ((fall && !w && !d) || m) m_mask = q;
    if (fall) m_inrow = 1'b1; else if (r) m_inrow = 1'b0;
    if (c || r) m_taken = 1'b0; else if (t) m_taken = 1'b1;
    m_rq = r;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic r;
    void'($urandom(32'd20240611));
    #22 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", lane_wen, '1);
    chk("R1", {{(L-1){1'b0}}, data_take}, '0);
    // R3 / R5: reload 1010, hold while dq changes
    step(1,1,1,0,4'h0,0);
    step(0,1,0,0,4'b1010,0);
    step(0,1,0,0,4'b0101,0);
    step(0,0,0,0,4'b0000,0);   // data_take R7
    step(0,0,0,0,4'b1111,0);   // no repeat
    step(1,1,1,0,4'b0000,0);
    // R4: persistent reuses 1010
    step(0,1,0,1,4'b0011,0);
    step(0,1,0,1,4'b0011,0);
    step(1,1,1,1,4'b0000,0);
    // R2: unmasked leaves mask
    step(0,1,1,0,4'b0001,0);
    step(0,0,1,0,4'b0001,0);
    step(0,0,0,0,4'b0001,0);   // R7 later of cas/we
    step(1,1,1,0,4'b0000,0);
    step(0,1,0,1,4'b0000,0);   // keep still 1010
    // R9 / R8: load mid-row, seen in next persistent cycle
    step(0,1,0,1,4'b0110,1);
    step(0,1,0,1,4'b0000,0);
    step(1,1,1,1,4'b0000,0);
    step(0,1,0,1,4'b0000,0);
    step(0,1,0,1,4'b0000,0);
    step(1,1,1,0,4'b0000,0);
    // random mix
    r = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0,5) == 0) r = ~r;
      step(r, 1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
           ($urandom_range(0,3) != 0), 4'($urandom_range(0,15)),
           ($urandom_range(0,15) == 0));
    end
    @(negedge clk);
    chk(m_tag, lane_wen, m_wen);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule